// File: doc/BRIEF.md
# Three-Channel Match and Overflow Timer

This peripheral holds three independent counters, each with a reload value and two compare values, all reachable over a plain word-addressed register bus. Each counter can be started and stopped on its own, can count up or down, and advances either on every bus clock or on each clock in which a shared external tick strobe is high. On reaching a compare value, or on wrapping (passing the all-ones value when counting up, leaving zero when counting down), the counter raises an event that sets a sticky status bit.

The status bits sit behind a mask register and are combined into one registered interrupt line. Software typically uses one counter as a free-running time base and another as an event source, either periodic (reload set so that a wrap occurs every N ticks) or one-shot (compare value set ahead of the live count).

Top module: `tri_timer`

## Requirements
- R1: After reset every register reads zero, the interrupt output is low and read data is zero.
- R2: Byte addresses map as follows: channel c register r at 16*c + 4*r, with r = 0 count, 1 reload, 2 compare-1, 3 compare-2; control at 0x30, status at 0x34, mask at 0x38. Read data appears one clock after the address. Unused control, status and mask bits read zero; unmapped or unaligned addresses read zero and ignore writes.
- R3: Control bits 3c, 3c+1 and 3c+2 are enable, tick select and wrap-event enable of channel c; bit 9+c set selects counting up. A channel whose enable bit is clear holds its count.
- R4: With tick select 0 and direction up, an enabled count increments once per bus clock.
- R5: With direction bit clear, an enabled count decrements once per tick.
- R6: With tick select 1, the count advances only in clocks where the external tick input is high.
- R7: Counting up, a tick at 0xFFFFFFFF loads the reload value and raises the wrap event; a reload of 0xFFFFFFFF-(N-1) gives a wrap every N ticks.
- R8: Counting down, a tick at zero loads the reload value and raises the wrap event.
- R9: A tick that moves the count onto a compare value raises that compare event; status bit 3c is compare-1, 3c+1 compare-2, 3c+2 wrap of channel c.
- R10: With the wrap-event enable bit clear, a wrap still reloads the count but sets no status bit.
- R11: Status bits stay set until software writes 1 to them; writing 0 leaves a bit unchanged.
- R12: The interrupt output is the OR of status bits whose mask bit is 0, registered, so it follows a status or mask change by one clock.
- R13: A bus write to a count register overrides that clock's tick and raises no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| ext_tick | input | 1 | External tick strobe, already synchronous |
| irq_out | output | 1 | Combined registered interrupt |

## Verification
A register write takes effect at the edge that samples it, and a control write only changes counting from the following edge, so a run bracketed by an enabling write and a disabling write with K idle clocks between them advances by exactly K+1 ticks; the bench stops each channel before reading so the expected count is exact. Read data is due one clock after the address, status bits move at the same edge as the count that caused them, and the interrupt line one edge later; the bench samples every result on the falling edge after the edge that should produce it, and checks the interrupt both before and after that extra edge when a mask changes.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;
  localparam int REGS_PER_CH = 4;
  localparam int REG_COUNT   = 0;
  localparam int REG_LOAD    = 1;
  localparam int REG_M1      = 2;
  localparam int REG_M2      = 3;

  localparam int EV_N   = 3;
  localparam int EV_M1  = 0;
  localparam int EV_M2  = 1;
  localparam int EV_OVF = 2;

  localparam int CTL_PER_CH = 3;

  typedef struct packed {
    logic up;
    logic ovf_en;
    logic clk_sel;
    logic en;
  } ch_ctrl_t;
endpackage

// File: rtl/tri_timer_chan.sv
module tri_timer_chan
  import tri_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  ch_ctrl_t               ctrl,
  input  logic                   ext_tick,
  input  logic [REGS_PER_CH-1:0] reg_we,
  input  logic [DATA_W-1:0]      wdata,
  output logic [DATA_W-1:0]      regs_o [REGS_PER_CH],
  output logic [EV_N-1:0]        ev
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic [DATA_W-1:0] reg_q [REGS_PER_CH];
  logic              tick, adv, at_end;
  logic [DATA_W-1:0] cnt_step, cnt_adv;

  // reload and compare registers: plain storage
  for (genvar r = 1; r < REGS_PER_CH; r++) begin : g_store
    always_ff @(posedge clk) begin
      if (rst)            reg_q[r] <= '0;
      else if (reg_we[r]) reg_q[r] <= wdata;
    end
  end

  always_comb begin
    tick     = ctrl.en & (ctrl.clk_sel ? ext_tick : 1'b1);
    adv      = tick & ~reg_we[REG_COUNT];
    at_end   = ctrl.up ? (reg_q[REG_COUNT] == ALL_ONES) : (reg_q[REG_COUNT] == '0);
    cnt_step = ctrl.up ? reg_q[REG_COUNT] + 1'b1 : reg_q[REG_COUNT] - 1'b1;
    cnt_adv  = at_end ? reg_q[REG_LOAD] : cnt_step;
    ev[EV_M1]  = adv & (cnt_adv == reg_q[REG_M1]);
    ev[EV_M2]  = adv & (cnt_adv == reg_q[REG_M2]);
    ev[EV_OVF] = adv & at_end & ctrl.ovf_en;
  end

  // counter: bus write wins over the tick
  always_ff @(posedge clk) begin
    if (rst)                    reg_q[REG_COUNT] <= '0;
    else if (reg_we[REG_COUNT]) reg_q[REG_COUNT] <= wdata;
    else if (adv)               reg_q[REG_COUNT] <= cnt_adv;
  end

  for (genvar r = 0; r < REGS_PER_CH; r++) begin : g_out
    assign regs_o[r] = reg_q[r];
  end

  // R3: disabled channel keeps its count
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.en && !reg_we[REG_COUNT]) |=> $stable(reg_q[REG_COUNT]));

  // R13: bus write lands regardless of tick
  p_write_wins_r13: assert property (@(posedge clk) disable iff (rst)
    reg_we[REG_COUNT] |=> (reg_q[REG_COUNT] == $past(wdata)));

  // R4: bus-clock up counting steps by one below the top value
  p_up_step_r4: assert property (@(posedge clk) disable iff (rst)
    (ctrl.en && !ctrl.clk_sel && ctrl.up && !reg_we[REG_COUNT] &&
     reg_q[REG_COUNT] != ALL_ONES)
    |=> (reg_q[REG_COUNT] == $past(reg_q[REG_COUNT]) + 1'b1));

  // R7/R8: a wrap event leaves the reload value in the counter
  p_reload_r7: assert property (@(posedge clk) disable iff (rst)
    ev[EV_OVF] |=> (reg_q[REG_COUNT] == $past(reg_q[REG_LOAD])));
endmodule

// File: rtl/tri_timer_evt.sv
module tri_timer_evt #(
  parameter int NEV = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NEV-1:0] ev,
  input  logic           clr_we,
  input  logic           mask_we,
  input  logic [NEV-1:0] wdata,
  output logic [NEV-1:0] status,
  output logic [NEV-1:0] mask,
  output logic           irq
);
  logic [NEV-1:0] stat_q, mask_q, clr_bits;
  logic           irq_q;

  assign clr_bits = clr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr_bits) | ev;
      if (mask_we) mask_q <= wdata;
      irq_q  <= |(stat_q & ~mask_q);
    end
  end

  assign status = stat_q;
  assign mask   = mask_q;
  assign irq    = irq_q;

  // R11: without a clearing write no status bit drops
  p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    !clr_we |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R9: every event lands in its status bit
  p_event_sets_r9: assert property (@(posedge clk) disable iff (rst)
    (ev != '0) |=> ((stat_q & $past(ev)) == $past(ev)));

  // R12: interrupt rises only from an unmasked pending bit
  p_irq_source_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> ($past(stat_q & ~mask_q) != '0));
endmodule

// File: rtl/tri_timer.sv
module tri_timer
  import tri_timer_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ext_tick,
  output logic              irq_out
);
  localparam int CH_WORDS = NUM_CH * REGS_PER_CH;
  localparam int W_CTRL   = CH_WORDS;
  localparam int W_STAT   = CH_WORDS + 1;
  localparam int W_MASK   = CH_WORDS + 2;
  localparam int CTRL_W   = (CTL_PER_CH + 1) * NUM_CH;
  localparam int NEV_ALL  = EV_N * NUM_CH;
  localparam int WORD_W   = ADDR_W - 2;
  localparam int SEL_W    = WORD_W - 2;

  logic [WORD_W-1:0] word_idx;
  logic [SEL_W-1:0]  ch_sel;
  logic [1:0]        reg_sel;
  logic              aligned, in_ch, wr;
  logic              ctrl_we, stat_we, mask_we;

  logic [CTRL_W-1:0]  ctrl_q;
  logic [DATA_W-1:0]  rd_nxt, rdata_q;
  logic [REGS_PER_CH-1:0] reg_we [NUM_CH];
  logic [DATA_W-1:0]  ch_regs [NUM_CH][REGS_PER_CH];
  logic [NEV_ALL-1:0] ev_all, status, mask;
  ch_ctrl_t           ch_ctrl [NUM_CH];

  // address decode
  always_comb begin
    word_idx = bus_addr[ADDR_W-1:2];
    aligned  = (bus_addr[1:0] == 2'b00);
    ch_sel   = word_idx[WORD_W-1:2];
    reg_sel  = word_idx[1:0];
    in_ch    = (int'(word_idx) < CH_WORDS);
    wr       = bus_we & aligned;
    ctrl_we  = wr & (int'(word_idx) == W_CTRL);
    stat_we  = wr & (int'(word_idx) == W_STAT);
    mask_we  = wr & (int'(word_idx) == W_MASK);
    for (int c = 0; c < NUM_CH; c++) begin
      for (int r = 0; r < REGS_PER_CH; r++) begin
        reg_we[c][r] = wr & in_ch & (ch_sel == SEL_W'(c)) & (reg_sel == 2'(r));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= bus_wdata[CTRL_W-1:0];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_ctrl[c].en      = ctrl_q[CTL_PER_CH*c];
    assign ch_ctrl[c].clk_sel = ctrl_q[CTL_PER_CH*c + 1];
    assign ch_ctrl[c].ovf_en  = ctrl_q[CTL_PER_CH*c + 2];
    assign ch_ctrl[c].up      = ctrl_q[CTL_PER_CH*NUM_CH + c];

    tri_timer_chan #(.DATA_W(DATA_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .ctrl     (ch_ctrl[c]),
      .ext_tick (ext_tick),
      .reg_we   (reg_we[c]),
      .wdata    (bus_wdata),
      .regs_o   (ch_regs[c]),
      .ev       (ev_all[EV_N*c +: EV_N])
    );
  end

  tri_timer_evt #(.NEV(NEV_ALL)) u_evt (
    .clk     (clk),
    .rst     (rst),
    .ev      (ev_all),
    .clr_we  (stat_we),
    .mask_we (mask_we),
    .wdata   (bus_wdata[NEV_ALL-1:0]),
    .status  (status),
    .mask    (mask),
    .irq     (irq_out)
  );

  // read mux, registered
  always_comb begin
    rd_nxt = '0;
    if (aligned) begin
      if (in_ch) begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (ch_sel == SEL_W'(c)) rd_nxt = ch_regs[c][reg_sel];
        end
      end else if (int'(word_idx) == W_CTRL) begin
        rd_nxt = DATA_W'(ctrl_q);
      end else if (int'(word_idx) == W_STAT) begin
        rd_nxt = DATA_W'(status);
      end else if (int'(word_idx) == W_MASK) begin
        rd_nxt = DATA_W'(mask);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_nxt;
  end

  assign bus_rdata = rdata_q;

  // R2: a write to an unmapped word changes no control state
  p_unmapped_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !aligned) |=> $stable(ctrl_q));
endmodule

// File: tb/tri_timer_tb_top.sv
module tri_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        ext_tick;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  tri_timer dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_tick(ext_tick), .irq_out(irq_out)
  );

  localparam logic [7:0] A_CTRL = 8'h30;
  localparam logic [7:0] A_STAT = 8'h34;
  localparam logic [7:0] A_MASK = 8'h38;

  function automatic logic [7:0] ra(int ch, int r);
    return 8'(16*ch + 4*r);
  endfunction

  // {addr, write data, expected read}
  localparam int NV = 12;
  localparam logic [71:0] VEC [NV] = '{
    {8'h04, 32'h0000_1234, 32'h0000_1234},
    {8'h08, 32'hA5A5_0001, 32'hA5A5_0001},
    {8'h0C, 32'hA5A5_0002, 32'hA5A5_0002},
    {8'h14, 32'h0000_5678, 32'h0000_5678},
    {8'h18, 32'hA5A5_0011, 32'hA5A5_0011},
    {8'h1C, 32'hA5A5_0012, 32'hA5A5_0012},
    {8'h28, 32'hA5A5_0021, 32'hA5A5_0021},
    {8'h2C, 32'hA5A5_0022, 32'hA5A5_0022},
    {8'h30, 32'hFFFF_F000, 32'h0000_0000},
    {8'h38, 32'hFFFF_FFFF, 32'h0000_01FF},
    {8'h3C, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h05, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; write lands at the next rising edge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h3C;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
    bus_addr = 8'h3C;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // enable at one edge, K idle clocks, stop at a later edge: K+1 ticks
  task automatic run(logic [31:0] ctl, int k);
    wr(A_CTRL, ctl);
    idle(k);
    wr(A_CTRL, ctl & 32'hFFFF_FEB6);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] d;
    rst = 1'b1; bus_addr = 8'h3C; bus_we = 1'b0; bus_wdata = '0; ext_tick = 1'b0;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    chk("R1 rdata", bus_rdata, 32'h0);
    chk("R1 irq", 32'(irq_out), 32'h0);
    for (int c = 0; c < 3; c++) begin
      rd(ra(c, 0), d); chk("R1 count", d, 32'h0);
      rd(ra(c, 2), d); chk("R1 match1", d, 32'h0);
    end
    rd(A_CTRL, d); chk("R1 ctrl", d, 32'h0);
    rd(A_STAT, d); chk("R1 status", d, 32'h0);
    rd(A_MASK, d); chk("R1 mask", d, 32'h0);

    // R2 register map table
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], d);
      chk("R2 map", d, VEC[i][31:0]);
    end
    rd(A_MASK, d); chk("R2 mask after unaligned", d, 32'h1FF);
    wr(A_MASK, 32'h0);

    // R4 up count on bus clock
    wr(ra(0, 0), 32'd100);
    run(32'h201, 6);
    rd(ra(0, 0), d); chk("R4 up count", d, 32'd107);
    // R3 hold while disabled
    idle(5);
    rd(ra(0, 0), d); chk("R3 hold", d, 32'd107);

    // R5 down count
    wr(ra(1, 0), 32'd20);
    run(32'h008, 4);
    rd(ra(1, 0), d); chk("R5 down count", d, 32'd15);

    // R8 down wrap at zero
    wr(ra(1, 1), 32'd10);
    wr(ra(1, 0), 32'd2);
    wr(A_STAT, 32'h1FF);
    run(32'h028, 3);
    rd(ra(1, 0), d); chk("R8 down reload", d, 32'd9);
    rd(A_STAT, d); chk("R8 wrap status", d, 32'h020);

    // R7 up wrap
    wr(A_STAT, 32'h1FF);
    wr(ra(0, 1), 32'h1000);
    wr(ra(0, 0), 32'hFFFF_FFFD);
    run(32'h205, 3);
    rd(ra(0, 0), d); chk("R7 up reload", d, 32'h1001);
    rd(A_STAT, d); chk("R7 wrap status", d, 32'h004);

    // R7 period of N=5 ticks, 12 ticks run
    wr(A_STAT, 32'h1FF);
    wr(ra(2, 1), 32'hFFFF_FFFB);
    wr(ra(2, 0), 32'hFFFF_FFFB);
    run(32'h940, 11);
    rd(ra(2, 0), d); chk("R7 period", d, 32'hFFFF_FFFD);
    rd(A_STAT, d); chk("R7 period status", d, 32'h100);

    // R10 wrap without event enable
    wr(A_STAT, 32'h1FF);
    wr(ra(0, 1), 32'h50);
    wr(ra(0, 0), 32'hFFFF_FFFF);
    run(32'h201, 0);
    rd(ra(0, 0), d); chk("R10 reload", d, 32'h50);
    rd(A_STAT, d); chk("R10 no status", d, 32'h0);

    // R9 compare-1 up
    wr(ra(2, 2), 32'h303);
    wr(ra(2, 3), 32'h400);
    wr(ra(2, 1), 32'h0);
    wr(ra(2, 0), 32'h300);
    run(32'h840, 4);
    rd(ra(2, 0), d); chk("R9 count", d, 32'h305);
    rd(A_STAT, d); chk("R9 match1 status", d, 32'h040);

    // R9 compare-2 down
    wr(A_STAT, 32'h1FF);
    wr(ra(1, 3), 32'd5);
    wr(ra(1, 0), 32'd8);
    run(32'h008, 3);
    rd(ra(1, 0), d); chk("R9 down count", d, 32'd4);
    rd(A_STAT, d); chk("R9 match2 status", d, 32'h010);

    // R12 interrupt follows unmasked status, one edge late on mask
    chk("R12 irq pending", 32'(irq_out), 32'h1);
    wr(A_MASK, 32'h010);
    chk("R12 irq one edge late", 32'(irq_out), 32'h1);
    idle(1);
    chk("R12 irq masked", 32'(irq_out), 32'h0);
    wr(A_MASK, 32'h0);
    idle(1);
    chk("R12 irq unmasked", 32'(irq_out), 32'h1);

    // R11 write-one-to-clear
    wr(A_STAT, 32'h0EF);
    rd(A_STAT, d); chk("R11 other bits kept", d, 32'h010);
    wr(A_STAT, 32'h010);
    rd(A_STAT, d); chk("R11 cleared", d, 32'h0);
    idle(1);
    chk("R11 irq low", 32'(irq_out), 32'h0);

    // R6 external tick: 3 strobes inside an 8-clock run
    wr(ra(0, 0), 32'h0);
    wr(A_CTRL, 32'h203);
    ext_tick = 1'b1; idle(1);
    ext_tick = 1'b0; idle(2);
    ext_tick = 1'b1; idle(2);
    ext_tick = 1'b0; idle(3);
    wr(A_CTRL, 32'h0);
    rd(ra(0, 0), d); chk("R6 ext ticks", d, 32'd3);
    // R3 strobe ignored while disabled
    ext_tick = 1'b1; idle(4); ext_tick = 1'b0;
    rd(ra(0, 0), d); chk("R3 ext while off", d, 32'd3);

    // R13 count write beats the tick and raises no compare event
    wr(A_STAT, 32'h1FF);
    wr(ra(2, 2), 32'd500);
    wr(ra(2, 0), 32'h10);
    wr(A_CTRL, 32'h840);
    wr(ra(2, 0), 32'd500);
    wr(A_CTRL, 32'h0);
    rd(ra(2, 0), d); chk("R13 count", d, 32'd501);
    rd(A_STAT, d); chk("R13 no event", d, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule